// File: doc/BRIEF.md
# Receive Byte Ordering Aligner

This block sits on a two-byte-wide receive datapath, after the word aligner and the byte deserializer. The word aligner fixes the bit boundary of each byte but not which of the two lanes holds the first byte of a word. The block finds a known marker byte (the ordering pattern) in the incoming words and, if the marker shows up in the upper lane, delays the byte stream by one byte. The marker then lands in the lower lane, and a fill byte takes the single slot that the shift opens.

A search starts on an edge event. In sync mode the event is a rising edge of the word aligner's lock flag. In user mode it is a rising edge of a request input. The choice between the two modes is made by a static parameter. Once the marker has been found, the block raises its aligned flag and keeps the chosen lane offset until the next trigger edge. The flag rises whether or not a fill byte was needed.

Top module: `byte_order_aligner`

## Requirements
- R1: On synchronous reset, `data_o` is 0, `aligned_o` is 0 and the lane offset returns to zero, so the first word after reset passes straight through.
- R2: Lane convention: `data_i[7:0]` is the earlier byte of a word and `data_i[15:8]` is the later one. With offset zero, `data_o` equals the `data_i` of the previous clock edge.
- R3: In sync mode, a rising edge of `sync_i` (sampled at a clock edge, compared with its value at the previous edge) drives `aligned_o` low after that edge and starts a search. The word presented in the edge cycle is not searched.
- R4: During a search, a word whose lower byte equals PATTERN sets `aligned_o` after that edge, and the word leaves unchanged (no fill byte).
- R5: During a search with offset zero, a word whose upper byte alone equals PATTERN sets `aligned_o` and produces `data_o[7:0]` = PAD and `data_o[15:8]` = that word's lower byte. From then on, each output word carries the previous input word's upper byte in bits [7:0] and the current input word's lower byte in bits [15:8].
- R6: If both bytes of a searched word equal PATTERN, the lower lane wins and offset zero is chosen.
- R7: While aligned, the block does not search. A marker in the upper lane, or a falling edge of a trigger, changes neither the offset nor `aligned_o`.
- R8: A new search that finds the marker in the lower lane while the offset is one drops the back to offset zero. The pending upper byte is dropped and no fill byte is emitted.
- R9: In user mode, a rising edge of `ord_en_i` clears `aligned_o` and starts a search. Edges of `sync_i` have no effect on the status or the data.
- R10: In sync mode, `ord_en_i` has no effect.
- R11: A searched word with PATTERN in neither lane keeps `aligned_o` low, keeps the search going and leaves the offset unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Parallel receive clock |
| rst_i | input | 1 | Synchronous active-high reset |
| sync_i | input | 1 | Lock flag from the word aligner |
| ord_en_i | input | 1 | User request that starts a search |
| data_i | input | 16 | Deserialized word, bits [7:0] earlier byte |
| data_o | output | 16 | Reordered word, registered |
| aligned_o | output | 1 | Marker found since the last trigger |

## Verification
The main function is exercised with words that carry the marker in the lower lane only, in the upper lane only, in both lanes, and in neither lane. These cases separate a pass-through result from a fill-byte shift, show which lane wins when both match, and show that a miss keeps the search open. Marker bytes placed on the trigger cycle itself, and again while the block is already aligned, show that only the words after a trigger are searched. The same trigger sequences are applied to both mode variants. This shows that each mode responds only to its own trigger input. A mid-stream reset with the offset at one shows that the shift is removed.

// File: rtl/byteord_pkg.sv
package byteord_pkg;

    localparam int BYTE_W = 8;
    localparam int LANES  = 2;
    localparam int WORD_W = BYTE_W * LANES;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        byte_t hi;
        byte_t lo;
    } word_t;

    typedef enum logic {
        TRIG_SYNC = 1'b0,
        TRIG_USER = 1'b1
    } trig_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_HOLD   = 2'd2
    } ord_state_e;

    typedef enum logic {
        OFS_NONE = 1'b0,
        OFS_ONE  = 1'b1
    } lane_ofs_e;

    typedef struct packed {
        logic hi_hit;
        logic lo_hit;
    } lane_hit_t;

    function automatic lane_hit_t match_lanes(word_t w, byte_t pat);
        lane_hit_t h;
        h.lo_hit = (w.lo == pat);
        h.hi_hit = (w.hi == pat);
        return h;
    endfunction

    // Lower lane has priority when both lanes carry the marker.
    function automatic lane_ofs_e pick_offset(lane_hit_t h);
        return h.lo_hit ? OFS_NONE : OFS_ONE;
    endfunction

endpackage

// File: rtl/byteord_edge_det.sv
module byteord_edge_det #(
    parameter int WIDTH = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] level_i,
    output logic [WIDTH-1:0] rise_o
);
    logic [WIDTH-1:0] level_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) level_q <= '0;
        else       level_q <= level_i;
    end

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        assign rise_o[b] = level_i[b] & ~level_q[b];
    end
endmodule

// File: rtl/byteord_ctrl.sv
module byteord_ctrl
    import byteord_pkg::*;
#(
    parameter trig_mode_e MODE    = TRIG_SYNC,
    parameter byte_t      PATTERN = 8'hBC
) (
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      sync_rise_i,
    input  logic      user_rise_i,
    input  word_t     din_i,
    output lane_ofs_e ofs_cur_o,
    output lane_ofs_e ofs_next_o,
    output logic      aligned_o,
    output logic      searching_o,
    output logic      trig_o
);
    ord_state_e state_q, state_d;
    lane_ofs_e  ofs_q, ofs_d;
    logic       al_q, al_d;
    lane_hit_t  hit;
    logic       trig;

    assign trig = (MODE == TRIG_USER) ? user_rise_i : sync_rise_i;
    assign hit  = match_lanes(din_i, PATTERN);

    always_comb begin
        state_d = state_q;
        ofs_d   = ofs_q;
        al_d    = al_q;
        if (trig) begin
            state_d = ST_SEARCH;
            al_d    = 1'b0;
        end else if (state_q == ST_SEARCH && (hit.lo_hit || hit.hi_hit)) begin
            state_d = ST_HOLD;
            ofs_d   = pick_offset(hit);
            al_d    = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_IDLE;
            ofs_q   <= OFS_NONE;
            al_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            ofs_q   <= ofs_d;
            al_q    <= al_d;
        end
    end

    assign ofs_cur_o   = ofs_q;
    assign ofs_next_o  = ofs_d;
    assign aligned_o   = al_q;
    assign searching_o = (state_q == ST_SEARCH);
    assign trig_o      = trig;
endmodule

// File: rtl/byteord_shifter.sv
module byteord_shifter
    import byteord_pkg::*;
#(
    parameter byte_t PAD = 8'h9C
) (
    input  logic      clk_i,
    input  logic      rst_i,
    input  word_t     din_i,
    input  lane_ofs_e ofs_cur_i,
    input  lane_ofs_e ofs_next_i,
    output word_t     dout_o
);
    byte_t hi_q;
    word_t dout_q, dout_d;

    always_comb begin
        if (ofs_next_i == OFS_NONE) begin
            dout_d = din_i;
        end else begin
            dout_d.hi = din_i.lo;
            // First shifted word: the freed slot gets the fill byte.
            dout_d.lo = (ofs_cur_i == OFS_NONE) ? PAD : hi_q;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            hi_q   <= '0;
            dout_q <= '0;
        end else begin
            hi_q   <= din_i.hi;
            dout_q <= dout_d;
        end
    end

    assign dout_o = dout_q;
endmodule

// File: rtl/byte_order_aligner.sv
module byte_order_aligner
    import byteord_pkg::*;
#(
    parameter trig_mode_e MODE    = TRIG_SYNC,
    parameter byte_t      PATTERN = 8'hBC,
    parameter byte_t      PAD     = 8'h9C
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              sync_i,
    input  logic              ord_en_i,
    input  logic [WORD_W-1:0] data_i,
    output logic [WORD_W-1:0] data_o,
    output logic              aligned_o
);
    logic [1:0] rise;
    lane_ofs_e  ofs_cur, ofs_next;
    logic       searching;
    logic       trig;
    logic       ofs_shift;
    word_t      din_w, dout_w;

    assign din_w = word_t'(data_i);

    byteord_edge_det #(.WIDTH(2)) u_edge (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .level_i ({ord_en_i, sync_i}),
        .rise_o  (rise)
    );

    byteord_ctrl #(.MODE(MODE), .PATTERN(PATTERN)) u_ctrl (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .sync_rise_i (rise[0]),
        .user_rise_i (rise[1]),
        .din_i       (din_w),
        .ofs_cur_o   (ofs_cur),
        .ofs_next_o  (ofs_next),
        .aligned_o   (aligned_o),
        .searching_o (searching),
        .trig_o      (trig)
    );

    byteord_shifter #(.PAD(PAD)) u_shift (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .din_i      (din_w),
        .ofs_cur_i  (ofs_cur),
        .ofs_next_i (ofs_next),
        .dout_o     (dout_w)
    );

    assign data_o    = dout_w;
    assign ofs_shift = (ofs_cur == OFS_ONE);
endmodule

// File: rtl/byteord_checker.sv
module byteord_checker
    import byteord_pkg::*;
#(
    parameter trig_mode_e MODE    = TRIG_SYNC,
    parameter byte_t      PATTERN = 8'hBC,
    parameter byte_t      PAD     = 8'h9C
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              sync_i,
    input logic              ord_en_i,
    input logic [WORD_W-1:0] data_i,
    input logic [WORD_W-1:0] data_o,
    input logic              aligned_o,
    input logic              searching,
    input logic              ofs_shift
);
    logic rst_q = 1'b0;
    logic sync_q, en_q;
    logic trig, lo_hit, hi_hit;

    always_ff @(posedge clk_i) begin
        rst_q <= rst_i;
        if (rst_i) begin
            sync_q <= 1'b0;
            en_q   <= 1'b0;
        end else begin
            sync_q <= sync_i;
            en_q   <= ord_en_i;
        end
    end

    assign trig   = (MODE == TRIG_USER) ? (ord_en_i & ~en_q) : (sync_i & ~sync_q);
    assign lo_hit = (data_i[BYTE_W-1:0] == PATTERN);
    assign hi_hit = (data_i[WORD_W-1:BYTE_W] == PATTERN);

    assert_reset_clear_R1: assert property (@(posedge clk_i)
        rst_q |-> (data_o == '0 && !aligned_o));

    assert_trigger_restart_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        trig |=> (!aligned_o && searching));

    assert_lower_lane_pass_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (searching && !trig && lo_hit) |=> (aligned_o && data_o == $past(data_i)));

    assert_pad_insert_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (searching && !trig && !lo_hit && hi_hit && !ofs_shift) |=>
        (aligned_o && data_o[BYTE_W-1:0] == PAD &&
         data_o[WORD_W-1:BYTE_W] == $past(data_i[BYTE_W-1:0])));

    assert_hold_aligned_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (aligned_o && !trig) |=> aligned_o);

    assert_miss_keeps_search_R11: assert property (@(posedge clk_i) disable iff (rst_i)
        (searching && !trig && !lo_hit && !hi_hit) |=> (searching && !aligned_o));
endmodule

bind byte_order_aligner byteord_checker #(
    .MODE(MODE), .PATTERN(PATTERN), .PAD(PAD)
) u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .sync_i    (sync_i),
    .ord_en_i  (ord_en_i),
    .data_i    (data_i),
    .data_o    (data_o),
    .aligned_o (aligned_o),
    .searching (searching),
    .ofs_shift (ofs_shift)
);

// File: tb/byte_order_aligner_test.sv
`timescale 1ns/1ps
module byte_order_aligner_test;
    import byteord_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sync_a = 1'b0, en_a = 1'b0;
    logic [15:0] din_a = 16'h0;
    logic [15:0] dout_a;
    logic        al_a;
    logic        sync_u = 1'b0, en_u = 1'b0;
    logic [15:0] din_u = 16'h0;
    logic [15:0] dout_u;
    logic        al_u;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    byte_order_aligner #(.MODE(TRIG_SYNC), .PATTERN(8'hBC), .PAD(8'h9C)) uut (
        .clk_i(clk), .rst_i(rst), .sync_i(sync_a), .ord_en_i(en_a),
        .data_i(din_a), .data_o(dout_a), .aligned_o(al_a)
    );

    byte_order_aligner #(.MODE(TRIG_USER), .PATTERN(8'hBC), .PAD(8'h9C)) uut_usr (
        .clk_i(clk), .rst_i(rst), .sync_i(sync_u), .ord_en_i(en_u),
        .data_i(din_u), .data_o(dout_u), .aligned_o(al_u)
    );

    // {sync, en, data_i, expected data_o, expected aligned}
    localparam int NVEC = 13;
    localparam logic [34:0] VEC_TBL [NVEC] = '{
        {1'b0, 1'b0, 16'h1122, 16'h1122, 1'b0},  // R2 pass-through
        {1'b1, 1'b0, 16'h33BC, 16'h33BC, 1'b0},  // R3 edge word not searched
        {1'b1, 1'b0, 16'hBC44, 16'h449C, 1'b1},  // R5 fill byte
        {1'b1, 1'b0, 16'h6655, 16'h55BC, 1'b1},  // R5 shifted stream
        {1'b1, 1'b0, 16'hBC77, 16'h7766, 1'b1},  // R7 no search while aligned
        {1'b0, 1'b0, 16'h8899, 16'h99BC, 1'b1},  // R7 falling edge ignored
        {1'b1, 1'b0, 16'hAAAA, 16'hAA88, 1'b0},  // R3 new edge clears
        {1'b1, 1'b0, 16'hBCBC, 16'hBCBC, 1'b1},  // R6 both lanes, R8 drop back
        {1'b1, 1'b1, 16'h1234, 16'h1234, 1'b1},  // R10 enable ignored
        {1'b0, 1'b0, 16'h0000, 16'h0000, 1'b1},  // R10
        {1'b1, 1'b0, 16'h00BC, 16'h00BC, 1'b0},  // R3
        {1'b1, 1'b0, 16'h1111, 16'h1111, 1'b0},  // R11 miss
        {1'b1, 1'b0, 16'h22BC, 16'h22BC, 1'b1}   // R4 lower lane
    };
    string vec_req [NVEC] = '{"R2", "R3", "R5", "R5", "R7", "R7", "R3",
                              "R6", "R10", "R10", "R3", "R11", "R4"};

    task automatic check(input string req, input logic [15:0] got_d, input logic [15:0] exp_d,
                         input logic got_a, input logic exp_a);
        checks++;
        if (got_d !== exp_d || got_a !== exp_a) begin
            errors++;
            $display("FAIL %s: data_o=%h aligned_o=%b expected data_o=%h aligned_o=%b",
                     req, got_d, got_a, exp_d, exp_a);
        end
    endtask

    task automatic step_a(input logic s, input logic e, input logic [15:0] d);
        @(negedge clk);
        sync_a = s; en_a = e; din_a = d;
        @(posedge clk);
        #1;
    endtask

    task automatic step_u(input logic s, input logic e, input logic [15:0] d);
        @(negedge clk);
        sync_u = s; en_u = e; din_u = d;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset sync-mode", dout_a, 16'h0000, al_a, 1'b0);
        check("R1 reset user-mode", dout_u, 16'h0000, al_u, 1'b0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            step_a(VEC_TBL[i][34], VEC_TBL[i][33], VEC_TBL[i][32:17]);
            check(vec_req[i], dout_a, VEC_TBL[i][16:1], al_a, VEC_TBL[i][0]);
        end

        // User mode: sync edges ignored, enable edges trigger (R9)
        step_u(1'b1, 1'b0, 16'hBC00);
        check("R9 sync edge ignored", dout_u, 16'hBC00, al_u, 1'b0);
        step_u(1'b1, 1'b1, 16'h0000);
        check("R9 enable edge", dout_u, 16'h0000, al_u, 1'b0);
        step_u(1'b1, 1'b1, 16'hBC12);
        check("R9 upper marker", dout_u, 16'h129C, al_u, 1'b1);
        step_u(1'b0, 1'b1, 16'h3456);
        check("R9 shifted", dout_u, 16'h56BC, al_u, 1'b1);
        step_u(1'b1, 1'b1, 16'h7890);
        check("R9 sync rise no effect", dout_u, 16'h9034, al_u, 1'b1);
        step_u(1'b1, 1'b0, 16'h0000);
        check("R9 enable fall", dout_u, 16'h0078, al_u, 1'b1);
        step_u(1'b1, 1'b1, 16'h5555);
        check("R9 re-trigger clears", dout_u, 16'h5500, al_u, 1'b0);
        step_u(1'b1, 1'b1, 16'h12BC);
        check("R8 back to offset zero", dout_u, 16'h12BC, al_u, 1'b1);

        // Mid-stream reset with offset one (R1)
        step_a(1'b0, 1'b0, 16'h0000);
        check("R7 hold", dout_a, 16'h0000, al_a, 1'b1);
        step_a(1'b1, 1'b0, 16'h0000);
        check("R3 edge", dout_a, 16'h0000, al_a, 1'b0);
        step_a(1'b1, 1'b0, 16'hBC01);
        check("R5 fill byte", dout_a, 16'h019C, al_a, 1'b1);
        @(negedge clk);
        rst = 1'b1;
        step_a(1'b1, 1'b0, 16'h5678);
        check("R1 reset mid-stream", dout_a, 16'h0000, al_a, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        step_a(1'b1, 1'b0, 16'hABCD);
        check("R1 offset cleared", dout_a, 16'hABCD, al_a, 1'b0);
        step_a(1'b1, 1'b0, 16'hCDBC);
        check("R4 lower lane after reset", dout_a, 16'hCDBC, al_a, 1'b1);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule